// File: doc/BRIEF.md
# Cache Performance Counter Unit

This block counts activity of a shared cache and raises an interrupt when a counter rolls over. It holds sixteen programmable 64-bit event counters and a free-running 64-bit cycle counter. Each event counter has a 32-bit select register. Software writes one of eight event codes into it, and from then on the counter advances on every pulse of the cache event strobe that carries that code. The cycle counter needs no select register and advances on every clock while the unit is running.

Software reaches all state through a flat 64-bit register port with byte offsets. A write takes effect at the next rising clock edge. A read is combinational from the current address. A counter that rolls over from all-ones to zero latches a bit in a sticky overflow status word. That word is masked with a per-counter interrupt-enable word to drive a single level interrupt line. Software clears status bits by writing ones to them.

Top module: `cache_perf_mon`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Bit 0 of the control register at offset 0x040 is the run bit, and the other bits read zero. While the run bit is clear, no counter advances.
- R3: The cycle counter at offset 0x058 goes up by one on every clock edge while the run bit is set. The first increment comes on the edge after the one that sets the run bit.
- R4: Counter n has a 32-bit select register at 0x060 + 8·n and a count register at 0x160 + 8·n. The select register keeps only the low 32 bits of a write, and its upper 32 read bits are zero.
- R5: Strobe bit k of `evt_strobe` carries the event with code k in this list: 0 = 0x04000701 (read request), 1 = 0x03000001 (write request), 2 = 0x0003e001 (release request), 3 = 0x00901202 (read hit), 4 = 0x04008002 (read miss), 5 = 0x006c0002 (write hit), 6 = 0x03000002 (write miss), 7 = 0x00000403 (writeback). While running, each counter whose select equals that code gains one per strobe cycle. Several counters may share a code.
- R6: A counter whose select value is none of the eight codes never advances.
- R7: Any count register, the cycle counter included, takes an arbitrary 64-bit value written to it and reads it back live. A write in the same cycle as a counting strobe stores the written value.
- R8: A counter that advances from all-ones becomes zero and sets its overflow status bit on that same edge. Event counter n uses bit n, and the cycle counter uses bit 63.
- R9: The overflow status register is at offset 0x048. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R10: When a clearing write and a new overflow hit the same status bit on the same edge, the bit ends up set.
- R11: The interrupt-enable register at offset 0x050 keeps bits 0–15 and bit 63, and its other bits read zero. `irq_o` is high exactly when status AND enable is nonzero.
- R12: Reads of any other offset, including unaligned ones, return zero. Writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (12) | Byte offset for both read and write |
| reg_wr_en | input | 1 | Write strobe; stores reg_wdata at reg_addr on the clock edge |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| evt_strobe | input | 8 | One-cycle cache event pulses, bit order as in R5 |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The assertions assume that the address, write strobe and event strobes are known and stay stable across each rising edge. They also assume that at most one register is written per cycle, which follows from the single address port. The bench drives all inputs on the falling edge, so it respects both assumptions. It mixes random strobe patterns, including all eight events at once, with directed presets that run counters into wrap-around, and it places clearing writes in the same cycle as an overflow.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Number of distinct cache event strobes.
    localparam int EVT_KINDS = 8;

    // Event code carried by each strobe bit; index = strobe bit.
    localparam logic [31:0] EVT_CODE [EVT_KINDS] = '{
        32'h0400_0701,   // read request
        32'h0300_0001,   // write request
        32'h0003_e001,   // release request
        32'h0090_1202,   // read hit
        32'h0400_8002,   // read miss
        32'h006c_0002,   // write hit
        32'h0300_0002,   // write miss
        32'h0000_0403    // writeback
    };

    // Register byte offsets.
    localparam int OFS_CTRL   = 'h040;
    localparam int OFS_STAT   = 'h048;
    localparam int OFS_INTEN  = 'h050;
    localparam int OFS_CYCLE  = 'h058;
    localparam int OFS_SEL    = 'h060;
    localparam int OFS_CNT    = 'h160;
    localparam int REG_STRIDE = 8;

    localparam int DATA_W  = 64;
    localparam int CODE_W  = 32;
    localparam int CYC_BIT = 63;

    typedef struct packed {
        logic ctrl;
        logic stat;
        logic inten;
        logic cycle;
    } glob_hit_t;

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output glob_hit_t          glob_o,
    output logic [NUM_CNT-1:0] sel_o,
    output logic [NUM_CNT-1:0] cnt_o
);

    assign glob_o.ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
    assign glob_o.stat  = (addr_i == ADDR_W'(OFS_STAT));
    assign glob_o.inten = (addr_i == ADDR_W'(OFS_INTEN));
    assign glob_o.cycle = (addr_i == ADDR_W'(OFS_CYCLE));

    // One exact-match comparator per counter slot; unaligned or unlisted
    // offsets match nothing.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
        assign sel_o[i] = (addr_i == ADDR_W'(OFS_SEL + REG_STRIDE * i));
        assign cnt_o[i] = (addr_i == ADDR_W'(OFS_CNT + REG_STRIDE * i));
    end

endmodule

// File: rtl/pcu_evt_match.sv
module pcu_evt_match
    import pcu_pkg::*;
(
    input  logic [CODE_W-1:0]    code_i,
    input  logic [EVT_KINDS-1:0] strobe_i,
    output logic                 hit_o
);

    // The code compare depends only on the stored select value, so the
    // strobe path sees a single AND-OR level.
    logic [EVT_KINDS-1:0] code_eq;

    for (genvar k = 0; k < EVT_KINDS; k++) begin : g_code
        assign code_eq[k] = (code_i == EVT_CODE[k]);
    end

    assign hit_o = |(code_eq & strobe_i);

endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_i) begin
            cnt_q <= wdata_i;          // preset beats a count
        end else if (inc_i) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = inc_i & ~wr_i & (&cnt_q);

    // R3 R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i) |=> (cnt_q == $past(cnt_q) + W'(1)));

    // R2 R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !wr_i) |=> $stable(cnt_q));

    // R7
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_q == $past(wdata_i)));

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/cache_perf_mon.sv
module cache_perf_mon
    import pcu_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int ADDR_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [EVT_KINDS-1:0] evt_strobe,
    output logic                 irq_o
);

    // Status/enable bits that exist: one per event counter plus the cycle bit.
    localparam logic [DATA_W-1:0] OVF_MASK =
        (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CNT) - DATA_W'(1));

    glob_hit_t          glob;
    logic [NUM_CNT-1:0] sel_hit;
    logic [NUM_CNT-1:0] cnt_hit;

    logic               run_q;
    logic [DATA_W-1:0]  stat_q;
    logic [DATA_W-1:0]  inten_q;
    logic [CODE_W-1:0]  sel_q   [NUM_CNT];
    logic [DATA_W-1:0]  cnt_val [NUM_CNT];
    logic [DATA_W-1:0]  cyc_val;
    logic [NUM_CNT-1:0] evt_hit;
    logic [NUM_CNT-1:0] evt_wrap;
    logic               cyc_wrap;
    logic [DATA_W-1:0]  ovf_vec;
    logic [DATA_W-1:0]  clr_vec;

    pcu_decode #(
        .NUM_CNT (NUM_CNT),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .addr_i  (reg_addr),
        .glob_o  (glob),
        .sel_o   (sel_hit),
        .cnt_o   (cnt_hit)
    );

    // ------------------------------------------------------------------
    // Control, enable and select registers
    // ------------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            inten_q <= '0;
        end else begin
            if (reg_wr_en && glob.ctrl)  run_q   <= reg_wdata[0];
            if (reg_wr_en && glob.inten) inten_q <= reg_wdata & OVF_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CNT; i++) sel_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_CNT; i++) begin
                if (reg_wr_en && sel_hit[i]) sel_q[i] <= reg_wdata[CODE_W-1:0];
            end
        end
    end

    // ------------------------------------------------------------------
    // Counters
    // ------------------------------------------------------------------
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
        pcu_evt_match u_match (
            .code_i   (sel_q[i]),
            .strobe_i (evt_strobe),
            .hit_o    (evt_hit[i])
        );

        pcu_counter #(.W(DATA_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (run_q & evt_hit[i]),
            .wr_i    (reg_wr_en & cnt_hit[i]),
            .wdata_i (reg_wdata),
            .cnt_o   (cnt_val[i]),
            .wrap_o  (evt_wrap[i])
        );
    end

    pcu_counter #(.W(DATA_W)) u_cycle (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (run_q),
        .wr_i    (reg_wr_en & glob.cycle),
        .wdata_i (reg_wdata),
        .cnt_o   (cyc_val),
        .wrap_o  (cyc_wrap)
    );

    // ------------------------------------------------------------------
    // Overflow status: set beats clear
    // ------------------------------------------------------------------
    always_comb begin
        ovf_vec                = '0;
        ovf_vec[NUM_CNT-1:0]   = evt_wrap;
        ovf_vec[CYC_BIT]       = cyc_wrap;
    end

    assign clr_vec = (reg_wr_en && glob.stat) ? reg_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | ovf_vec;
        end
    end

    assign irq_o = |(stat_q & inten_q);

    // ------------------------------------------------------------------
    // Read mux
    // ------------------------------------------------------------------
    always_comb begin
        reg_rdata = '0;
        if (glob.ctrl)  reg_rdata = {{(DATA_W-1){1'b0}}, run_q};
        if (glob.stat)  reg_rdata = stat_q;
        if (glob.inten) reg_rdata = inten_q;
        if (glob.cycle) reg_rdata = cyc_val;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (sel_hit[i]) reg_rdata = {{(DATA_W-CODE_W){1'b0}}, sel_q[i]};
            if (cnt_hit[i]) reg_rdata = cnt_val[i];
        end
    end

    // R10
    ovf_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf_vec) |=> ((stat_q & $past(ovf_vec)) == $past(ovf_vec)));

    // R9
    status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ovf_vec)) == '0));

    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr_en && glob.ctrl)) |=> $stable(run_q));

endmodule

// File: tb/cache_perf_mon_tb_top.sv
`timescale 1ns/1ps
module cache_perf_mon_tb_top;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [63:0] wdata = '0;
    logic [7:0]  strb = '0;
    logic [63:0] rdata;
    logic        irq;

    always #2.5 clk = ~clk;   // 200 MHz

    cache_perf_mon dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (addr),
        .reg_wr_en  (wr),
        .reg_wdata  (wdata),
        .reg_rdata  (rdata),
        .evt_strobe (strb),
        .irq_o      (irq)
    );

    // Event codes as stated in R5 (bench's own copy of the requirement).
    logic [31:0] code_tab [8] = '{32'h04000701, 32'h03000001, 32'h0003e001,
                                  32'h00901202, 32'h04008002, 32'h006c0002,
                                  32'h03000002, 32'h00000403};
    localparam logic [63:0] EN_MASK = 64'h8000_0000_0000_FFFF;
    localparam logic [63:0] ONES    = 64'hFFFF_FFFF_FFFF_FFFF;

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_cnt [N];
    logic [31:0] m_sel [N];
    logic [63:0] m_cyc, m_stat, m_inten;
    logic        m_run;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always @(posedge clk) begin : ref_model
        logic [63:0] ovf;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
            m_cyc = '0; m_stat = '0; m_inten = '0; m_run = 1'b0;
        end else begin
            ovf = '0;
            for (int i = 0; i < N; i++) begin
                bit hit;
                hit = 0;
                for (int k = 0; k < 8; k++)
                    if (strb[k] && m_sel[i] == code_tab[k]) hit = 1;
                if (wr && addr == 12'h160 + 12'(8 * i)) m_cnt[i] = wdata;
                else if (m_run && hit) begin
                    if (m_cnt[i] == ONES) ovf[i] = 1'b1;
                    m_cnt[i] = m_cnt[i] + 64'd1;
                end
            end
            if (wr && addr == 12'h058) m_cyc = wdata;
            else if (m_run) begin
                if (m_cyc == ONES) ovf[63] = 1'b1;
                m_cyc = m_cyc + 64'd1;
            end
            if (wr && addr == 12'h048) m_stat = m_stat & ~wdata;
            m_stat = m_stat | ovf;
            if (wr && addr == 12'h040) m_run = wdata[0];
            if (wr && addr == 12'h050) m_inten = wdata & EN_MASK;
            for (int i = 0; i < N; i++)
                if (wr && addr == 12'h060 + 12'(8 * i)) m_sel[i] = wdata[31:0];
        end
    end

    function automatic logic [63:0] exp_rd(input logic [11:0] a);
        logic [63:0] v;
        v = '0;
        if (a == 12'h040) v = {63'b0, m_run};
        if (a == 12'h048) v = m_stat;
        if (a == 12'h050) v = m_inten;
        if (a == 12'h058) v = m_cyc;
        for (int i = 0; i < N; i++) begin
            if (a == 12'h060 + 12'(8 * i)) v = {32'b0, m_sel[i]};
            if (a == 12'h160 + 12'(8 * i)) v = m_cnt[i];
        end
        return v;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (!rst_n) return "R1";
        if (a == 12'h040) return "R2";
        if (a == 12'h048) return "R9";
        if (a == 12'h050) return "R11";
        if (a == 12'h058) return "R3";
        if (a >= 12'h060 && a < 12'h0E0 && a[2:0] == 3'b0) return "R4";
        if (a >= 12'h160 && a < 12'h1E0 && a[2:0] == 3'b0) return "R5";
        return "R12";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at falling edge, compare at the next falling edge.
    task automatic cyc(input logic [11:0] a, input logic w, input logic [63:0] d,
                       input logic [7:0] s);
        addr = a; wr = w; wdata = d; strb = s;
        @(negedge clk);
        check(tag_of(a), rdata, exp_rd(a));
        check("R11 irq", {63'b0, irq}, {63'b0, |(m_stat & m_inten)});
    endtask

    task automatic rd(input logic [11:0] a);
        cyc(a, 1'b0, '0, '0);
    endtask

    task automatic wrt(input logic [11:0] a, input logic [63:0] d);
        cyc(a, 1'b1, d, '0);
    endtask

    function automatic logic [11:0] rand_addr();
        int r;
        r = $urandom_range(0, 35);
        if (r < 16) return 12'h060 + 12'(8 * r);
        if (r < 32) return 12'h160 + 12'(8 * (r - 16));
        if (r == 32) return 12'h040;
        if (r == 33) return 12'h048;
        if (r == 34) return 12'h050;
        return 12'h058;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] snap;
        @(negedge clk);
        // R1: during reset
        for (int c = 0; c < 3; c++) rd(12'h058);
        rst_n = 1'b1;
        // R1: all registers zero after reset
        for (int i = 0; i < N; i++) begin
            rd(12'h160 + 12'(8 * i)); check("R1 counter", rdata, 64'd0);
            rd(12'h060 + 12'(8 * i)); check("R1 select", rdata, 64'd0);
        end
        rd(12'h048); check("R1 status", rdata, 64'd0);
        check("R1 irq", {63'b0, irq}, 64'd0);

        // R4: program selects; slot 14 and 15 get unlisted codes (R6)
        for (int i = 0; i < 14; i++) wrt(12'h060 + 12'(8 * i), {32'hFFFF_FFFF, code_tab[i % 8]});
        wrt(12'h060 + 12'(8 * 14), 64'd0);
        wrt(12'h060 + 12'(8 * 15), 64'h12345678);
        rd(12'h060 + 12'(8 * 5)); check("R4 select upper bits dropped", rdata, {32'b0, code_tab[5]});

        // R2: not running, strobes have no effect
        for (int c = 0; c < 3; c++) cyc(12'h160, 1'b0, '0, 8'hFF);
        check("R2 counter idle", rdata, 64'd0);
        rd(12'h058); check("R2 cycle idle", rdata, 64'd0);

        // R11: enable mask
        wrt(12'h050, ONES); check("R11 enable mask", rdata, EN_MASK);
        wrt(12'h050, 64'h8000_0000_0000_FFFD);

        // R2/R3: start running
        wrt(12'h040, 64'hFFFF); check("R2 run bit", rdata, 64'd1);
        rd(12'h058); check("R3 first tick", rdata, 64'd1);
        rd(12'h058); check("R3 second tick", rdata, 64'd2);

        // R5: read request strobes
        for (int c = 0; c < 3; c++) cyc(12'h160, 1'b0, '0, 8'h01);
        check("R5 counter0", rdata, 64'd3);
        rd(12'h160 + 12'(8 * 8)); check("R5 shared code", rdata, 64'd3);
        cyc(12'h160, 1'b0, '0, 8'hFF);
        cyc(12'h160, 1'b0, '0, 8'hFF);
        check("R5 all strobes", rdata, 64'd5);
        rd(12'h160 + 12'(8 * 15)); check("R6 unlisted code", rdata, 64'd0);
        rd(12'h160 + 12'(8 * 14)); check("R6 zero code", rdata, 64'd0);

        // random phase
        for (int c = 0; c < 300; c++) cyc(rand_addr(), 1'b0, '0, 8'($urandom));

        // R8: event counter wrap
        wrt(12'h048, ONES);
        wrt(12'h178, 64'hFFFF_FFFF_FFFF_FFFE);
        cyc(12'h178, 1'b0, '0, 8'h08); check("R8 near wrap", rdata, ONES);
        cyc(12'h178, 1'b0, '0, 8'h08); check("R8 wrapped", rdata, 64'd0);
        rd(12'h048); check("R8 status bit3", rdata, 64'h8);
        check("R11 irq raised", {63'b0, irq}, 64'd1);

        // R9: write-one-to-clear
        wrt(12'h048, 64'd0); check("R9 zero write keeps", rdata, 64'h8);
        wrt(12'h048, 64'h8); check("R9 one write clears", rdata, 64'd0);
        check("R11 irq dropped", {63'b0, irq}, 64'd0);

        // R10: clear and overflow on same edge
        wrt(12'h160, ONES);
        cyc(12'h048, 1'b1, ONES, 8'h01); check("R10 overflow wins", rdata, 64'h1);

        // R7: preset beats a count
        cyc(12'h168, 1'b1, 64'h1234, 8'h02); check("R7 preset wins", rdata, 64'h1234);
        rd(12'h168); check("R7 preset holds", rdata, 64'h1234);

        // R8: cycle counter wrap, bit 63
        wrt(12'h048, ONES);
        wrt(12'h058, 64'hFFFF_FFFF_FFFF_FFFE); check("R7 cycle preset", rdata, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(12'h058);
        rd(12'h058); check("R8 cycle wrapped", rdata, 64'd0);
        rd(12'h048); check("R8 status bit63", rdata, 64'h8000_0000_0000_0000);
        check("R11 cycle irq", {63'b0, irq}, 64'd1);
        wrt(12'h050, 64'd0); check("R11 masked irq", {63'b0, irq}, 64'd0);

        // R12: unmapped offsets
        wrt(12'h008, ONES); check("R12 read 0x008", rdata, 64'd0);
        wrt(12'h0E0, ONES); check("R12 read 0x0E0", rdata, 64'd0);
        wrt(12'h1E0, ONES); check("R12 read 0x1E0", rdata, 64'd0);
        wrt(12'h044, ONES); check("R12 read 0x044", rdata, 64'd0);
        wrt(12'h05C, ONES); check("R12 read 0x05C", rdata, 64'd0);
        rd(12'h050); check("R12 enable untouched", rdata, 64'd0);
        rd(12'h040); check("R12 control untouched", rdata, 64'd1);

        // R2: stop running
        wrt(12'h040, 64'd0);
        rd(12'h058); snap = rdata;
        for (int c = 0; c < 3; c++) cyc(12'h058, 1'b0, '0, 8'hFF);
        check("R2 cycle frozen", rdata, snap);
        rd(12'h160); check("R2 counter frozen", rdata, 64'd0);

        // random phase while stopped, then running again
        for (int c = 0; c < 100; c++) cyc(rand_addr(), 1'b0, '0, 8'($urandom));
        wrt(12'h040, 64'd1);
        wrt(12'h050, ONES);
        for (int c = 0; c < 200; c++) cyc(rand_addr(), 1'b0, '0, 8'($urandom));

        done = 1;
        summary();
        $finish;
    end

endmodule